// File: doc/BRIEF.md
# Serial gain word transmitter

This block is the host-side writer for an amplifier whose gain is set through a three-wire serial port. A one-cycle start request with a parallel gain code opens a write. The block pulls the active-low enable line down and presents the most significant bit. It then sends a burst of exactly `WORD_W` serial clock pulses that carry the code MSB first. After a short tail it releases the enable line, which makes the amplifier apply the new word, and raises a one-cycle done pulse in the same cycle.

The serial clock is gated. It stays low at all times except during the burst, so no clock edges reach the amplifier between writes. All analog timing limits are expressed as counts of system clock cycles: the lead from enable fall to the first rising clock, the clock high width, the low gap between pulses, and the tail before the enable is released. With the default counts and a 5 ns system clock, the burst has a 35 ns clock period and a 15 ns high width. Data has 20 ns of setup before each rising edge and 15 ns of hold after it, and the enable has 20 ns of setup.

A separate power control bit from the host is carried through a short register chain to the active-low power-down line. It is independent of the write sequencer and can change in the middle of a write.

Top module: `sgw_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are: enable high, serial clock low, serial data low, busy low, done low and power-down line low.
- R2: When start is sampled high with busy low, the enable goes low and busy goes high in the next cycle, and the serial data shows bit `WORD_W-1` of the code. A fall of the enable only ever follows an accepted start.
- R3: Each write has exactly `WORD_W` serial clock pulses (8 by default). The serial clock is never high while the enable is high.
- R4: The bit seen on serial data at the k-th rising serial clock (k counted from 0) is bit `WORD_W-1-k` of the code captured at start. A code of 8'hA5 therefore sends 1,0,1,0,0,1,0,1. Serial data is low whenever the block is idle.
- R5: Serial data does not change while the serial clock is high. It changes only in the cycle the clock falls.
- R6: The enable is low for exactly `LEAD_CYC` cycles before the first rising clock. Each clock high phase lasts `HIGH_CYC` cycles and each low gap between pulses lasts `LOW_CYC` cycles. The clock stays low for exactly `TAIL_CYC` cycles after the last falling edge before the enable rises.
- R7: In the cycle the enable returns high, done is high for exactly one cycle and busy is low.
- R8: A start request made while busy is ignored: the word sent is unchanged and no second write follows.
- R9: The power-down line equals the power control input delayed by `SYNC_STAGES` cycles (2 by default). Changing the input during a write does not disturb the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Write request, sampled each cycle |
| code_i | input | WORD_W | Gain code captured on an accepted start |
| pwr_on_i | input | 1 | Host power control bit (1 = amplifier on) |
| sen_n_o | output | 1 | Active-low serial enable to the amplifier |
| sclk_o | output | 1 | Gated serial clock, idles low |
| sdata_o | output | 1 | Serial data, MSB first |
| busy_o | output | 1 | High while a write is in progress |
| done_o | output | 1 | One-cycle pulse when the enable is released |
| pd_n_o | output | 1 | Active-low power-down line to the amplifier |

## Verification
A phase counter that is off by one shows up in the next sample as a lead, high, low or tail width that differs from its parameter. The bench measures each of these widths per write. A shifter or bit counter that is out of step shows up by the end of the same write, either as a wrong reassembled word or as a pulse count other than `WORD_W`. A sequencer that accepts a start while busy, or that leaves the idle state with no start, shows up within a cycle as an extra fall of the enable or a clock edge while the enable is high. All 256 codes are swept, some with start and power toggles injected mid-write, so an error that depends on the code appears within that code's own write.

// File: rtl/sgw_pkg.sv
// Shared types for the serial gain word transmitter.
// Assumes: nothing beyond the standard language.
package sgw_pkg;

    // Phases of one serial write.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_HIGH = 3'd2,
        ST_LOW  = 3'd3,
        ST_TAIL = 3'd4
    } seq_state_t;

endpackage

// File: rtl/sgw_phase_timer.sv
// Down-counter that measures how long each phase of a write lasts.
// A load sets the count to (length - 1). expired_o is high in the last cycle
// of the phase.
// Assumes: the loaded value fits in CNT_W bits.
module sgw_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Reload at a phase boundary, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sgw_word_shifter.sv
// Holds the gain word being sent and counts the bits that are still to go.
// bit_o is the current MSB; last_o marks that the final bit is on the line.
// Assumes: shift_i is given only between bits, never after the last one.
module sgw_word_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] code_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);

    localparam int LEFT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] word_q;
    logic [LEFT_W-1:0] left_q;

    // Capture the code on load, move it one place toward the MSB on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            word_q <= code_i;
            left_q <= LEFT_W'(WORD_W);
        end else if (shift_i) begin
            word_q <= {word_q[WORD_W-2:0], 1'b0};
            left_q <= left_q - LEFT_W'(1);
        end
    end

    assign bit_o  = word_q[WORD_W-1];
    assign last_o = (left_q == LEFT_W'(1));

endmodule

// File: rtl/sgw_level_sync.sv
// Register chain that carries the host power bit to the power-down line.
// Assumes: STAGES >= 1. The output resets low, which keeps the amplifier off.
module sgw_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            // A single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= d_i;
            end
        end else begin : g_chain
            // A multi-stage shift chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sgw_sequencer.sv
// Phase sequencer of one serial write: idle, lead, a number of high/low
// pulses, then tail. Every output is registered from the next state, so each
// phase is seen at the pins for exactly its programmed number of cycles.
// Assumes: the phase lengths are >= 1 and fit in CNT_W bits after the -1.
module sgw_sequencer #(
    parameter int LEAD_CYC = 4,
    parameter int HIGH_CYC = 3,
    parameter int LOW_CYC  = 4,
    parameter int TAIL_CYC = 1,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tmr_expired_i,
    input  logic             last_bit_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             sh_load_o,
    output logic             sh_shift_o,
    output logic             sen_n_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             done_o
);

    import sgw_pkg::*;

    localparam logic [CNT_W-1:0] LEAD_V = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] LOW_V  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_V = CNT_W'(TAIL_CYC - 1);

    seq_state_t state_q;
    seq_state_t state_nx;

    // Next phase, plus the timer and shifter commands for the boundary.
    always_comb begin
        state_nx   = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        sh_load_o  = 1'b0;
        sh_shift_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_nx   = ST_LEAD;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = LEAD_V;
                    sh_load_o  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_expired_i) begin
                    state_nx   = ST_HIGH;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = HIGH_V;
                end
            end
            ST_HIGH: begin
                if (tmr_expired_i) begin
                    tmr_load_o = 1'b1;
                    if (last_bit_i) begin
                        state_nx  = ST_TAIL;
                        tmr_val_o = TAIL_V;
                    end else begin
                        state_nx   = ST_LOW;
                        tmr_val_o  = LOW_V;
                        sh_shift_o = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (tmr_expired_i) begin
                    state_nx   = ST_HIGH;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = HIGH_V;
                end
            end
            ST_TAIL: begin
                if (tmr_expired_i) begin
                    state_nx = ST_IDLE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // Register the phase and decode the pin levels from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sen_n_o <= 1'b1;
            sclk_o  <= 1'b0;
            busy_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_nx;
            sen_n_o <= (state_nx == ST_IDLE);
            sclk_o  <= (state_nx == ST_HIGH);
            busy_o  <= (state_nx != ST_IDLE);
            done_o  <= (state_q == ST_TAIL) && (state_nx == ST_IDLE);
        end
    end

endmodule

// File: rtl/sgw_tx.sv
// Serial gain word transmitter, top level. It joins the sequencer, the phase
// timer, the word shifter and the power-line register chain.
// Assumes: the system clock period times each *_CYC count meets the
// amplifier's minimum times. Bad counts stop elaboration.
module sgw_tx #(
    parameter int WORD_W      = 8,
    parameter int LEAD_CYC    = 4,
    parameter int HIGH_CYC    = 3,
    parameter int LOW_CYC     = 4,
    parameter int TAIL_CYC    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] code_i,
    input  logic              pwr_on_i,
    output logic              sen_n_o,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pd_n_o
);

    localparam int MAX_A   = (LEAD_CYC > HIGH_CYC) ? LEAD_CYC : HIGH_CYC;
    localparam int MAX_B   = (LOW_CYC > TAIL_CYC) ? LOW_CYC : TAIL_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    generate
        if (LEAD_CYC < 1 || HIGH_CYC < 1 || LOW_CYC < 1 || TAIL_CYC < 1 ||
            WORD_W < 2 || SYNC_STAGES < 1) begin : g_bad_cfg
            $error("sgw_tx: every phase count and SYNC_STAGES must be >= 1, WORD_W >= 2");
        end
    endgenerate

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             sh_load;
    logic             sh_shift;
    logic             cur_bit;
    logic             last_bit;
    logic             busy_w;

    sgw_sequencer #(
        .LEAD_CYC (LEAD_CYC),
        .HIGH_CYC (HIGH_CYC),
        .LOW_CYC  (LOW_CYC),
        .TAIL_CYC (TAIL_CYC),
        .CNT_W    (CNT_W)
    ) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .tmr_expired_i (tmr_expired),
        .last_bit_i    (last_bit),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .sh_load_o     (sh_load),
        .sh_shift_o    (sh_shift),
        .sen_n_o       (sen_n_o),
        .sclk_o        (sclk_o),
        .busy_o        (busy_w),
        .done_o        (done_o)
    );

    sgw_phase_timer #(
        .CNT_W (CNT_W)
    ) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    sgw_word_shifter #(
        .WORD_W (WORD_W)
    ) sh_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .code_i  (code_i),
        .shift_i (sh_shift),
        .bit_o   (cur_bit),
        .last_o  (last_bit)
    );

    sgw_level_sync #(
        .STAGES (SYNC_STAGES)
    ) pd_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pwr_on_i),
        .q_o   (pd_n_o)
    );

    assign busy_o  = busy_w;
    assign sdata_o = busy_w & cur_bit;

endmodule

// File: rtl/sgw_tx_chk.sv
// Temporal checks on the pins of sgw_tx. Bound to every instance of the top.
// Assumes: the same WORD_W as the instance it is bound to.
module sgw_tx_chk #(
    parameter int WORD_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic sen_n_o,
    input logic sclk_o,
    input logic sdata_o,
    input logic busy_o,
    input logic done_o
);

    localparam int PC_W = $clog2(WORD_W + 2);

    logic            sclk_d;
    logic [PC_W-1:0] pulse_cnt;

    // Count rising serial clock edges while the enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            pulse_cnt <= '0;
        end else begin
            sclk_d <= sclk_o;
            if (sen_n_o)                pulse_cnt <= '0;
            else if (sclk_o && !sclk_d) pulse_cnt <= pulse_cnt + PC_W'(1);
        end
    end

    AST_SCLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !sen_n_o); // R3

    AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_n_o) |-> (pulse_cnt == PC_W'(WORD_W))); // R3

    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R5

    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(sen_n_o)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sen_n_o) |-> $past(start_i && !busy_o)); // R2 R8

endmodule

bind sgw_tx sgw_tx_chk #(.WORD_W(WORD_W)) chk_i (.*);

// File: tb/sgw_tx_tb_top.sv
`timescale 1ns/1ps
module sgw_tx_tb_top;

    localparam int WORD_W      = 8;
    localparam int LEAD_CYC    = 4;
    localparam int HIGH_CYC    = 3;
    localparam int LOW_CYC     = 4;
    localparam int TAIL_CYC    = 1;
    localparam int SYNC_STAGES = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [WORD_W-1:0] code_in;
    logic              pwr_on;
    logic              sen_n, sclk, sdata, busy, done, pd_n;

    int n_checks = 0;
    int n_bad    = 0;

    always #2.5 clk = ~clk;

    sgw_tx #(
        .WORD_W (WORD_W), .LEAD_CYC (LEAD_CYC), .HIGH_CYC (HIGH_CYC),
        .LOW_CYC (LOW_CYC), .TAIL_CYC (TAIL_CYC), .SYNC_STAGES (SYNC_STAGES)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start), .code_i (code_in),
        .pwr_on_i (pwr_on), .sen_n_o (sen_n), .sclk_o (sclk), .sdata_o (sdata),
        .busy_o (busy), .done_o (done), .pd_n_o (pd_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    endtask

    // One write of 'code'. Optionally a second start while busy and a power flip mid-write.
    task automatic do_write(input logic [WORD_W-1:0] code, input bit poke,
                            input logic [WORD_W-1:0] other, input bit flip_pwr);
        int                len;
        int                pulses;
        int                samp;
        logic [WORD_W-1:0] word;
        bit                prev;
        bit                hold;
        @(negedge clk);
        start   = 1'b1;
        code_in = code;
        @(negedge clk);
        start   = 1'b0;
        code_in = ~code;
        chk(sen_n == 1'b0, "R2 enable low after start", sen_n, 0);
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(sdata == code[WORD_W-1], "R4 msb presented first", sdata, code[WORD_W-1]);
        prev = 1'b0; hold = 1'b0; len = 1; pulses = 0; samp = 0; word = '0;
        while (1) begin
            @(negedge clk);
            samp++;
            if (poke && samp == 3) begin start = 1'b1; code_in = other; end
            if (poke && samp == 4) start = 1'b0;
            if (flip_pwr && samp == 7) pwr_on = ~pwr_on;
            if (sen_n) begin
                chk(prev == 1'b0, "R6 clock low at release", prev, 0);
                chk(len == TAIL_CYC, "R6 tail width", len, TAIL_CYC);
                chk(done == 1'b1, "R7 done at release", done, 1);
                chk(busy == 1'b0, "R7 busy low at release", busy, 0);
                break;
            end
            chk(done == 1'b0, "R7 no done during write", done, 0);
            if (sclk != prev) begin
                if (sclk) begin
                    chk(len == ((pulses == 0) ? LEAD_CYC : LOW_CYC), "R6 lead or low width",
                        len, (pulses == 0) ? LEAD_CYC : LOW_CYC);
                    pulses++;
                    word = {word[WORD_W-2:0], sdata};
                    hold = sdata;
                end else begin
                    chk(len == HIGH_CYC, "R6 high width", len, HIGH_CYC);
                end
                len  = 1;
                prev = sclk;
            end else begin
                len++;
                if (sclk) chk(sdata == hold, "R5 data stable while clock high", sdata, hold);
            end
            if (samp > 2000) begin
                chk(1'b0, "R3 write never ended", samp, 0);
                break;
            end
        end
        chk(pulses == WORD_W, "R3 pulse count", pulses, WORD_W);
        chk(word == code, "R4 word sent MSB first", word, code);
        @(negedge clk);
        chk(done == 1'b0, "R7 done lasts one cycle", done, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(sen_n == 1'b1 && sclk == 1'b0,
                poke ? "R8 no write from ignored start" : "R3 clock idle low", sclk, 0);
            chk(sdata == 1'b0, "R4 data low when idle", sdata, 0);
        end
        if (flip_pwr) chk(pd_n == pwr_on, "R9 power line after mid-write change", pd_n, pwr_on);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL R3 watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; code_in = '0; pwr_on = 1'b0;
        repeat (3) @(negedge clk);
        chk(sen_n == 1'b1 && sclk == 1'b0 && sdata == 1'b0, "R1 serial pins in reset",
            {sen_n, sclk, sdata}, 4);
        chk(busy == 1'b0 && done == 1'b0, "R1 status in reset", {busy, done}, 0);
        chk(pd_n == 1'b0, "R1 power line in reset", pd_n, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sen_n == 1'b1 && sclk == 1'b0 && busy == 1'b0, "R1 idle after reset",
            {sen_n, sclk, busy}, 4);

        // Power line latency, both directions (R9).
        for (int v = 0; v < 2; v++) begin
            pwr_on = (v == 0);
            for (int c = 1; c <= SYNC_STAGES; c++) begin
                @(negedge clk);
                if (c < SYNC_STAGES) chk(pd_n == (v != 0), "R9 power line not yet changed", pd_n, v != 0);
                else                 chk(pd_n == (v == 0), "R9 power line after delay", pd_n, v == 0);
            end
        end
        pwr_on = 1'b1;
        repeat (SYNC_STAGES + 1) @(negedge clk);

        // Exhaustive sweep of codes with injected start pokes and power flips.
        for (int c = 0; c < (1 << WORD_W); c++) begin
            do_write(WORD_W'(c), (c % 16) == 5, ~WORD_W'(c), (c % 32) == 9);
        end

        summary();
        $finish;
    end

endmodule